// File: doc/BRIEF.md
# Debounced Level-Interrupt Input Controller

This block watches sixteen asynchronous input pins and turns sustained levels on them into interrupts. Every pin is first brought into the clock domain through two flops. It then feeds its own debounce stage, which runs only after software has armed it. When the pin has stayed at its selected active level for the programmed number of millisecond ticks, the stage sets a per-channel status bit. The status bits are gated by per-channel interrupt enables, and the gated bits are ORed onto one interrupt line.

Software sets everything up through a small register bus with a combinational read port. It can see the synchronized pin levels, with each channel gated by an enable. It chooses the active polarity of each channel, sets the interrupt enables, and reads status both before and after enable gating. It clears a status bit by writing a one to the acknowledge register. A fired channel disarms itself, so the next arm write is the only way to start a new debounce. Software can emulate an edge interrupt by flipping the polarity before it re-arms. Millisecond ticks come from a free-running prescaler. Its cycle count is a parameter.

Top module: `level_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 0.
- R2: The LEVEL register (offset 0x00) returns, for each bit n, the synchronized value of `pin_in[n]` when bit n of ENABLE (0x04) is 1. It returns 0 for bit n when that ENABLE bit is 0. A pin change shows up in LEVEL no later than three clocks after it occurs.
- R3: Bit n of POLARITY (0x08) selects the active level of channel n: 1 means high and 0 means low.
- R4: A RAWSTAT (0x10) bit can set only while its channel is armed. A channel is armed by writing 1 to its bit of ARM (0x1C). An active level held without an arm write never sets status.
- R5: The debounce length is bits 11:0 of the channel's control word at 0x40 + 4*n, counted in ticks, and a length of 0 counts as 1. After the arm write, status is still 0 at (L-1)*T - 1 clocks and is set by (L+1)*T + 2 clocks, where L is the effective length and T is the number of clocks per tick.
- R6: If the synchronized input leaves the active level during a debounce, the tick count starts again from zero.
- R7: PENDING (0x14) equals RAWSTAT ANDed with IRQEN (0x0C), and `irq_out` is 1 exactly when some PENDING bit is 1.
- R8: Writing ACK (0x18) clears each RAWSTAT bit written as 1 and leaves bits written as 0 unchanged. An acknowledge in the same clock as a status set wins.
- R9: When a status bit sets, its channel disarms. Once the bit is acknowledged it stays 0, even with the level still active, until the next arm write.
- R10: Each control word reads back its 12-bit length with the bits above it as 0.
- R11: Reading ARM returns, per channel, 1 while a debounce is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 16 | Asynchronous input pins |
| irq_out | output | 1 | Combined interrupt |

## Verification
Every channel in turn goes through the same sequence: it is armed with a debounce length between 0 and 3, and the even and odd channels use opposite polarities. The sequence includes a hold of the active level before arming, which separates "armed" from "merely active". A read just inside the minimum hold time and another just past the maximum separate a correct tick count from one that is off by one, and show that a zero length is treated as one. A glitch in the middle of a debounce separates a count that restarts from one that only pauses. A run with two channels pending and only one enabled separates the raw status from the gated status and shows that acknowledging one bit leaves the other untouched.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int DBW = 12;
  typedef logic [DBW-1:0] dbnc_t;

  localparam logic [7:0] OFS_LEVEL = 8'h00;
  localparam logic [7:0] OFS_EN    = 8'h04;
  localparam logic [7:0] OFS_POL   = 8'h08;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_RAW   = 8'h10;
  localparam logic [7:0] OFS_PEND  = 8'h14;
  localparam logic [7:0] OFS_ACK   = 8'h18;
  localparam logic [7:0] OFS_ARM   = 8'h1C;
  localparam logic [7:0] OFS_CTRL  = 8'h40;

  // effective tick count: zero behaves as one
  function automatic logic [DBW:0] need_ticks(dbnc_t len);
    return (len == '0) ? {{DBW{1'b0}}, 1'b1} : {1'b0, len};
  endfunction

  // true when the tick now arriving completes the hold
  function automatic logic hold_met(dbnc_t cnt, dbnc_t len);
    return ({1'b0, cnt} + 1'b1) >= need_ticks(len);
  endfunction
endpackage

// File: rtl/lic_tick.sv
module lic_tick #(
  parameter int TICK_CYC = 32000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(TICK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/lic_chan.sv
module lic_chan
  import lic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  pin,
  input  logic  pol,
  input  logic  arm_wr,
  input  logic  ack_wr,
  input  dbnc_t len,
  output logic  lvl,
  output logic  armed,
  output logic  fire,
  output logic  st
);
  logic  s1_q, s2_q;
  dbnc_t cnt_q;
  logic  active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
    end
  end

  assign lvl    = s2_q;
  assign active = (s2_q == pol);
  assign fire   = armed && !arm_wr && active && tick && hold_met(cnt_q, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (arm_wr) begin
      armed <= 1'b1;
      cnt_q <= '0;
    end else if (armed) begin
      if (!active) begin
        cnt_q <= '0;
      end else if (fire) begin
        armed <= 1'b0;
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= 1'b0;
    else if (ack_wr) st <= 1'b0;
    else if (fire)   st <= 1'b1;
  end
endmodule

// File: rtl/level_irq_ctrl.sv
module level_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int TICK_CYC = 32000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic          irq_out
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] CBASE = AW'(OFS_CTRL);
  localparam logic [AW:0]   CEND  = (AW+1)'(OFS_CTRL) + (AW+1)'(4 * NCH);

  logic [NCH-1:0] en_q, pol_q, ien_q;
  dbnc_t          len_q [NCH];
  logic [NCH-1:0] lvl_v, armed_v, fire_v, st_v, arm_v, ack_v, pend_v;
  logic           tick;
  logic           ctrl_hit;
  logic [AW-1:0]  ctrl_ofs;
  logic [IW-1:0]  ctrl_idx;

  lic_tick #(.TICK_CYC(TICK_CYC)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign ctrl_hit = ({1'b0, bus_addr} >= {1'b0, CBASE}) && ({1'b0, bus_addr} < CEND);
  assign ctrl_ofs = bus_addr - CBASE;
  assign ctrl_idx = ctrl_ofs[IW+1:2];

  assign arm_v = (bus_we && bus_addr == AW'(OFS_ARM)) ? bus_wdata[NCH-1:0] : '0;
  assign ack_v = (bus_we && bus_addr == AW'(OFS_ACK)) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      ien_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(OFS_EN))  en_q  <= bus_wdata[NCH-1:0];
      if (bus_addr == AW'(OFS_POL)) pol_q <= bus_wdata[NCH-1:0];
      if (bus_addr == AW'(OFS_IEN)) ien_q <= bus_wdata[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q[g] <= '0;
      else if (bus_we && ctrl_hit && ctrl_idx == IW'(g)) len_q[g] <= bus_wdata[DBW-1:0];
    end

    lic_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .pin(pin_in[g]), .pol(pol_q[g]),
      .arm_wr(arm_v[g]), .ack_wr(ack_v[g]), .len(len_q[g]),
      .lvl(lvl_v[g]), .armed(armed_v[g]), .fire(fire_v[g]), .st(st_v[g])
    );
  end

  assign pend_v  = st_v & ien_q;
  assign irq_out = |pend_v;

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) begin
      bus_rdata = DW'(len_q[ctrl_idx]);
    end else begin
      case (bus_addr)
        AW'(OFS_LEVEL): bus_rdata = DW'(lvl_v & en_q);
        AW'(OFS_EN):    bus_rdata = DW'(en_q);
        AW'(OFS_POL):   bus_rdata = DW'(pol_q);
        AW'(OFS_IEN):   bus_rdata = DW'(ien_q);
        AW'(OFS_RAW):   bus_rdata = DW'(st_v);
        AW'(OFS_PEND):  bus_rdata = DW'(pend_v);
        AW'(OFS_ARM):   bus_rdata = DW'(armed_v);
        default:        bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] fire_v,
  input logic [NCH-1:0] st_v,
  input logic [NCH-1:0] armed_v,
  input logic [NCH-1:0] arm_v,
  input logic [NCH-1:0] ack_v,
  input logic           irq_out
);
  // R8: an acknowledged bit is clear on the following clock, set or not
  p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_v) |=> ((st_v & $past(ack_v)) == '0));

  // R4: a status bit only rises on a channel that was armed
  p_set_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v & ~$past(st_v) & ~$past(armed_v)) == '0);

  // R9: a firing channel is disarmed afterwards unless re-armed that clock
  p_disarm_on_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_v) |=> ((armed_v & $past(fire_v) & ~$past(arm_v)) == '0));

  // R7: the interrupt line needs some status bit behind it
  p_irq_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|st_v));
endmodule

bind level_irq_ctrl lic_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_v(fire_v), .st_v(st_v),
  .armed_v(armed_v), .arm_v(arm_v), .ack_v(ack_v), .irq_out(irq_out)
);

// File: tb/sim_level_irq_ctrl.sv
module sim_level_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int T     = 4;
  localparam int NCH   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] pins = '0;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  level_irq_ctrl #(.NCH(NCH), .DW(16), .AW(8), .TICK_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .irq_out(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] pat_p [4];
    logic [15:0] pat_e [4];
    pat_p[0] = 16'hA5A5; pat_e[0] = 16'hFFFF;
    pat_p[1] = 16'hFFFF; pat_e[1] = 16'h0F0F;
    pat_p[2] = 16'h1234; pat_e[2] = 16'hF00F;
    pat_p[3] = 16'h0000; pat_e[3] = 16'hFFFF;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state of every register
    for (int a = 0; a < 8'h80; a += 4) begin
      rd(8'(a), v);
      check("R1 reset read", v, 16'h0000);
    end
    check("R1 irq after reset", {15'b0, irq}, 16'h0000);

    // R2: level visibility through the enable mask
    for (int p = 0; p < 4; p++) begin
      pins = pat_p[p];
      wr(8'h04, pat_e[p]);
      idle(3);
      rd(8'h00, v);
      check("R2 level gated by enable", v, pat_p[p] & pat_e[p]);
    end
    pins = '0;
    wr(8'h0C, 16'hFFFF);

    // per-channel sweep: polarity by parity, length c%4
    for (int c = 0; c < NCH; c++) begin
      logic pol;
      int len, eff, k;
      pol = c[0];
      len = c % 4;
      eff = (len == 0) ? 1 : len;
      pins = '0;
      pins[c] = ~pol;
      wr(8'h08, 16'(pol) << c);
      wr(8'h40 + 8'(4 * c), 16'(len));
      idle(3);
      pins[c] = pol;
      idle(5 * T);
      rd(8'h10, v);
      check("R4 active without arm", v, 16'h0000);
      wr(8'h1C, 16'h1 << c);
      rd(8'h1C, v);
      check("R11 armed flag", v, 16'h1 << c);
      k = (eff - 1) * T - 1;
      if (k >= 0) begin
        idle(k);
        rd(8'h10, v);
        check("R5 not yet set", v, 16'h0000);
      end else begin
        k = 0;
      end
      idle((eff + 1) * T + 2 - k);
      rd(8'h10, v);
      check(pol ? "R3 R5 set active-high" : "R3 R5 set active-low", v, 16'h1 << c);
      rd(8'h14, v);
      check("R7 pending enabled", v, 16'h1 << c);
      check("R7 irq high", {15'b0, irq}, 16'h0001);
      rd(8'h1C, v);
      check("R9 disarmed after set", v, 16'h0000);
      wr(8'h18, 16'h1 << c);
      rd(8'h10, v);
      check("R8 ack clears", v, 16'h0000);
      check("R8 irq low after ack", {15'b0, irq}, 16'h0000);
      idle(3 * T);
      rd(8'h10, v);
      check("R9 no refire without arm", v, 16'h0000);
    end

    // R7 / R8: two pending, one enabled, partial acknowledge
    pins = '0;
    wr(8'h08, 16'h0000);
    wr(8'h0C, 16'h0001);
    wr(8'h1C, 16'h0003);
    idle(3 * T + 4);
    rd(8'h10, v);
    check("R7 raw both", v, 16'h0003);
    rd(8'h14, v);
    check("R7 pending masked", v, 16'h0001);
    check("R7 irq with enabled pending", {15'b0, irq}, 16'h0001);
    wr(8'h18, 16'h0001);
    rd(8'h10, v);
    check("R8 zero bit untouched", v, 16'h0002);
    check("R7 irq masked only", {15'b0, irq}, 16'h0000);
    wr(8'h18, 16'h0002);

    // R6: a glitch restarts the count (channel 3, length 3, active high)
    pins = '0;
    wr(8'h08, 16'h0008);
    idle(3);
    wr(8'h1C, 16'h0008);
    pins[3] = 1'b1;
    idle(2 * T);
    pins[3] = 1'b0;
    idle(4);
    pins[3] = 1'b1;
    idle(2 * T);
    rd(8'h10, v);
    check("R6 count restarted", v, 16'h0000);
    idle(2 * T + 6);
    rd(8'h10, v);
    check("R6 set after full hold", v, 16'h0008);
    wr(8'h18, 16'h0008);

    // R10: length field width
    wr(8'h40 + 8'd20, 16'hFABC);
    rd(8'h40 + 8'd20, v);
    check("R10 length readback", v, 16'h0ABC);
    rd(8'h40 + 8'd24, v);
    check("R10 other channel kept", v, 16'h0002);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule